// File: doc/BRIEF.md
# Key-Protected System Control Register

This block is a single 32-bit control register on a simple register bus: a select line, a write enable, write data, and read data that is valid in the same cycle. Software changes the register only if the upper half of the write word carries a fixed unlock key. A write with any other key changes nothing at all.

The register holds a 3-bit priority-grouping field. That field sets where group priority ends and subpriority begins for an 8-bit interrupt priority. The block shows this split as a mask output. The register also reports a fixed endianness bit chosen by a parameter. It has a write-only action bit that raises a sticky system reset request toward an external reset controller. Two further write-only bits are reserved for debug. Setting either of them in an accepted write is tolerated: the two bits themselves are ignored, and a one-cycle error pulse is raised.

Top module: `sysctl_keyreg`

## Requirements
- R1: After a synchronous active-low reset, the grouping field is 0, so the mask is 8'hFE. The reset request output and the error flag are both 0.
- R2: A write (sel=1, wr_en=1) whose bits [31:16] equal 16'h05FA is accepted. From the next cycle, the grouping field holds write bits [10:8].
- R3: A write whose bits [31:16] differ from 16'h05FA changes nothing. This includes the readback constant 16'hFA05. The grouping field and the reset request keep their values, and no error pulse follows. A write with sel=0 is also ignored.
- R4: A read returns 16'hFA05 in bits [31:16], the endianness parameter in bit 15 (0 little, 1 big), and the grouping field in bits [10:8]. All other bits read 0: reserved bits [14:11] and [7:3], and the write-only bits [2:0].
- R5: An accepted write with bit 2 set raises the reset request output from the next cycle. The output then stays high through later writes until the block is reset.
- R6: An accepted write with bit 0 or bit 1 set still updates the grouping field and the reset request as usual. It also raises the error flag for exactly the next cycle.
- R7: For a grouping value n, the mask has bits [7:n+1] set (group priority) and bits [n:0] clear (subpriority). A value of 7 gives a mask of 0.
- R8: A read is combinational and has no side effects. A read in the same cycle as an accepted write returns the value held before that write.
- R9: With sel low, the read data is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel | input | 1 | Register select |
| wr_en | input | 1 | Write enable (qualified by sel) |
| wdata | input | 32 | Write data, key in bits [31:16] |
| rdata | output | 32 | Read data, combinational |
| rst_req | output | 1 | Sticky system reset request |
| wr_err | output | 1 | One-cycle pulse after an accepted write with debug bits set |
| grp_mask | output | 8 | Group-priority mask of the priority value |

## Verification
A register read and a register write can fall in the same cycle, because read data comes straight from the held state while the write lands at the clock edge. The bench provokes this by driving a keyed write with sel high. The scoreboard then expects the old grouping value on rdata during that cycle and the new value in the next cycle. A second overlap comes from an accepted write that both requests reset and sets a debug bit. For that write, the bench expects the reset request and the error pulse to appear together in the following cycle.

// File: rtl/sysctl_pkg.sv
// Shared constants and the decoded-write type for the key-protected control
// register. Assumes a 32-bit register with the key in the upper half.
package sysctl_pkg;
    localparam int REG_W     = 32;
    localparam int KEY_W     = 16;
    localparam int KEY_LSB   = REG_W - KEY_W;
    localparam logic [KEY_W-1:0] KEY_UNLOCK   = 16'h05FA;
    localparam logic [KEY_W-1:0] KEY_READBACK = 16'hFA05;
    localparam int ENDIAN_POS = 15;
    localparam int GRP_W     = 3;
    localparam int GRP_LSB   = 8;
    localparam int PRIO_W    = 8;
    localparam int RSTREQ_POS = 2;
    localparam int DBG_LSB   = 0;
    localparam int DBG_W     = 2;

    typedef struct packed {
        logic             accept;
        logic [GRP_W-1:0] grp;
        logic             rst_set;
        logic             dbg_hit;
    } wr_cmd_t;
endpackage

// File: rtl/sysctl_keygate.sv
// Decodes one bus cycle into a write command. A write is accepted only when
// sel and wr_en are high and the key field matches the unlock constant.
// Assumes that the reserved bits of the write word carry no meaning.
module sysctl_keygate
    import sysctl_pkg::*;
(
    input  logic             sel,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    output wr_cmd_t          cmd
);
    logic unused_bits;
    assign unused_bits = ^{wdata[KEY_LSB-1:GRP_LSB+GRP_W],
                           wdata[GRP_LSB-1:RSTREQ_POS+1]};

    // Key compare and field extraction for the current cycle.
    always_comb begin
        cmd.accept  = sel && wr_en && (wdata[REG_W-1:KEY_LSB] == KEY_UNLOCK);
        cmd.grp     = wdata[GRP_LSB +: GRP_W];
        cmd.rst_set = wdata[RSTREQ_POS];
        cmd.dbg_hit = |wdata[DBG_LSB +: DBG_W];
    end
endmodule

// File: rtl/sysctl_state.sv
// Holds the grouping field, the sticky reset request and the one-cycle
// error flag. Acts only on accepted commands. Synchronous active-low reset.
module sysctl_state
    import sysctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  wr_cmd_t          cmd,
    output logic [GRP_W-1:0] grp_q,
    output logic             rst_req_q,
    output logic             err_q
);
    // Register update on an accepted write; the reset request only sets.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grp_q     <= '0;
            rst_req_q <= 1'b0;
            err_q     <= 1'b0;
        end else begin
            err_q <= cmd.accept && cmd.dbg_hit;
            if (cmd.accept) begin
                grp_q <= cmd.grp;
                if (cmd.rst_set) begin
                    rst_req_q <= 1'b1;
                end
            end
        end
    end

    assert_rstreq_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_q |=> rst_req_q);
    assert_grp_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd.accept |=> $stable(grp_q));
    assert_err_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd.accept && cmd.dbg_hit) |=> err_q);
endmodule

// File: rtl/sysctl_prio_mask.sv
// Expands the grouping field n into a mask: bits above n mark group priority.
// Assumes PRIO_W <= 2**GRP_W.
module sysctl_prio_mask #(
    parameter int GRP_W  = 3,
    parameter int PRIO_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [GRP_W-1:0]  grp,
    output logic [PRIO_W-1:0] mask
);
    localparam int CW = GRP_W + 1;

    // One comparator per priority bit.
    for (genvar i = 0; i < PRIO_W; i++) begin : g_bit
        assign mask[i] = (CW'(i) > {1'b0, grp});
    end

    assert_mask_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(mask) == (PRIO_W - 1 - int'(grp)));
    assert_mask_contig_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mask ^ {mask[PRIO_W-2:0], 1'b0}));
endmodule

// File: rtl/sysctl_readmux.sv
// Builds the read word from the held state. Unused bits read zero.
// Purely combinational, with no side effects.
module sysctl_readmux
    import sysctl_pkg::*;
#(
    parameter logic BIG_ENDIAN = 1'b0
) (
    input  logic             sel,
    input  logic [GRP_W-1:0] grp,
    output logic [REG_W-1:0] rdata
);
    // Field placement of the readback word.
    always_comb begin
        rdata = '0;
        if (sel) begin
            rdata[REG_W-1:KEY_LSB]   = KEY_READBACK;
            rdata[ENDIAN_POS]        = BIG_ENDIAN;
            rdata[GRP_LSB +: GRP_W]  = grp;
        end
    end
endmodule

// File: rtl/sysctl_keyreg.sv
// Top of the key-protected system control register. Wires the key gate,
// the state registers, the mask expander and the read mux together.
// Assumes a single-cycle bus with no wait states.
module sysctl_keyreg
    import sysctl_pkg::*;
#(
    parameter logic BIG_ENDIAN = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    output logic              rst_req,
    output logic              wr_err,
    output logic [PRIO_W-1:0] grp_mask
);
    wr_cmd_t          cmd;
    logic [GRP_W-1:0] grp_q;

    sysctl_keygate u_gate (
        .sel   (sel),
        .wr_en (wr_en),
        .wdata (wdata),
        .cmd   (cmd)
    );

    sysctl_state u_state (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd       (cmd),
        .grp_q     (grp_q),
        .rst_req_q (rst_req),
        .err_q     (wr_err)
    );

    sysctl_prio_mask #(.GRP_W(GRP_W), .PRIO_W(PRIO_W)) u_mask (
        .clk   (clk),
        .rst_n (rst_n),
        .grp   (grp_q),
        .mask  (grp_mask)
    );

    sysctl_readmux #(.BIG_ENDIAN(BIG_ENDIAN)) u_rd (
        .sel   (sel),
        .grp   (grp_q),
        .rdata (rdata)
    );

    assert_wrong_key_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && wr_en && wdata[REG_W-1:KEY_LSB] != KEY_UNLOCK)
        |=> ($stable(rst_req) && !wr_err && $stable(grp_mask)));
    assert_readback_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sel |-> (rdata[GRP_LSB +: GRP_W] == grp_q));
    assert_idle_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |-> (rdata == '0));
endmodule

// File: tb/test_sysctl_keyreg.sv
module test_sysctl_keyreg;
    localparam logic ENDIAN = 1'b1;

    typedef struct {
        string       tag;
        logic [31:0] rdata;
        logic [7:0]  mask;
        logic        rreq;
        logic        err;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        rst_req;
    logic        wr_err;
    logic [7:0]  grp_mask;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;
    exp_t q[$];

    logic [2:0] m_grp = '0;
    logic       m_rreq = 1'b0;
    logic       m_err = 1'b0;

    sysctl_keyreg #(.BIG_ENDIAN(ENDIAN)) i_sysctl_keyreg (
        .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en), .wdata(wdata),
        .rdata(rdata), .rst_req(rst_req), .wr_err(wr_err), .grp_mask(grp_mask)
    );

    always #2 clk = ~clk;

    function automatic logic [7:0] mask_of(logic [2:0] n);
        logic [7:0] m;
        for (int i = 0; i < 8; i++) m[i] = (i > int'(n));
        return m;
    endfunction

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Driver: one bus cycle, pushing what must be seen during that cycle.
    task automatic op(string tag, logic s, logic w, logic [31:0] d);
        exp_t e;
        @(negedge clk);
        sel = s; wr_en = w; wdata = d;
        e.tag   = tag;
        e.rdata = s ? {16'hFA05, ENDIAN, 4'b0, m_grp, 8'b0} : 32'h0;
        e.mask  = mask_of(m_grp);
        e.rreq  = m_rreq;
        e.err   = m_err;
        q.push_back(e);
        if (s && w && d[31:16] == 16'h05FA) begin
            m_grp = d[10:8];
            if (d[2]) m_rreq = 1'b1;
            m_err = |d[1:0];
        end else begin
            m_err = 1'b0;
        end
    endtask

    function automatic logic [31:0] kw(logic [15:0] key, logic [2:0] g, logic [2:0] low);
        return {key, 5'b0, g, 5'b0, low};
    endfunction

    task automatic do_reset();
        @(negedge clk);
        sel = 1'b0; wr_en = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        m_grp = '0; m_rreq = 1'b0; m_err = 1'b0;
    endtask

    // Monitor: pops one expectation per bus cycle and compares.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                chk(e.tag, "rdata", rdata, e.rdata);
                chk(e.tag, "grp_mask", {24'h0, grp_mask}, {24'h0, e.mask});
                chk(e.tag, "rst_req", {31'h0, rst_req}, {31'h0, e.rreq});
                chk(e.tag, "wr_err", {31'h0, wr_err}, {31'h0, e.err});
            end
        end
    end

    // Watchdog.
    initial begin
        while (!done && cycles < 5000) begin
            @(posedge clk);
            cycles++;
        end
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=done", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        op("R1", 1'b0, 1'b0, '0);
        op("R4", 1'b1, 1'b0, '0);
        op("R2", 1'b1, 1'b1, kw(16'h05FA, 3'd3, 3'b000));
        op("R2", 1'b1, 1'b0, '0);
        op("R3", 1'b1, 1'b1, kw(16'h5FA0, 3'd6, 3'b111));
        op("R3", 1'b1, 1'b0, '0);
        op("R3", 1'b1, 1'b1, kw(16'hFA05, 3'd5, 3'b100));
        op("R3", 1'b0, 1'b1, kw(16'h05FA, 3'd1, 3'b100));
        op("R9", 1'b0, 1'b0, '0);
        op("R4", 1'b1, 1'b1, 32'h05FA_FFF8 & ~32'h0000_0700 | 32'h0000_0200);
        op("R4", 1'b1, 1'b0, '0);
        for (int n = 0; n < 8; n++) begin
            op("R7", 1'b1, 1'b1, kw(16'h05FA, 3'(n), 3'b000));
            op("R7", 1'b1, 1'b0, '0);
        end
        op("R6", 1'b1, 1'b1, kw(16'h05FA, 3'd2, 3'b001));
        op("R6", 1'b1, 1'b0, '0);
        op("R6", 1'b1, 1'b0, '0);
        op("R6", 1'b1, 1'b1, kw(16'h05FA, 3'd6, 3'b010));
        op("R6", 1'b1, 1'b0, '0);
        op("R8", 1'b1, 1'b1, kw(16'h05FA, 3'd4, 3'b000));
        op("R8", 1'b1, 1'b0, '0);
        op("R5", 1'b1, 1'b1, kw(16'h05FA, 3'd1, 3'b101));
        op("R5", 1'b1, 1'b1, kw(16'h05FA, 3'd0, 3'b000));
        op("R5", 1'b1, 1'b1, kw(16'h1234, 3'd7, 3'b000));
        op("R5", 1'b1, 1'b0, '0);
        op("R5", 1'b0, 1'b0, '0);
        do_reset();
        op("R1", 1'b1, 1'b0, '0);
        op("R1", 1'b0, 1'b0, '0);
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule